// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit down-counting timer channel. Each counting step is paced by a count-enable strobe (`tick`) and not by the clock. A load strobe writes a new initial value. On that same strobe the channel also takes in a 3-bit operating mode and a decimal-counting flag. The counter then produces a live count value and an `out` waveform that depends on the mode. The six modes are: terminal-count flag, gate-triggered one-shot, rate generator, square wave, software strobe and gate-triggered strobe. Mode codes 6 and 7 fold onto modes 2 and 3. The bus interface and any read latching are the job of a neighbouring block. That block only drives the load strobe and samples `count` and `out`.

Control is a five-state machine:
- `ST_IDLE`: the state after reset, before any load.
- `ST_ARMED`: loaded in a gate-triggered mode and waiting for a rising gate edge.
- `ST_RUN`: counting toward the end of a period.
- `ST_STROBE`: the single-tick pulse in modes 2, 4 and 5.
- `ST_TAIL`: a one-shot mode has expired, and the counter keeps wrapping.

Transitions:
- A load enters `ST_ARMED` (modes 1 and 5) or `ST_RUN` (all other modes).
- A trigger enters `ST_RUN` from any non-idle state.
- Expiry leads from `ST_RUN` to `ST_TAIL` (modes 0 and 1) or to `ST_STROBE` (modes 2, 4 and 5).
- From `ST_STROBE`, the next counting tick leads to `ST_TAIL` (modes 4 and 5) or back to `ST_RUN` (mode 2).
- In mode 3 the machine stays in `ST_RUN`, reloading at every period end.

A binary elapsed-tick counter runs beside the visible count. All period and duty decisions are made in binary, even when the visible count is decimal.

Top module: `interval_counter`

## Requirements
- R1: After reset `count` is 0 and `out` is 0, and ticks, gate activity and mode input changes have no effect until the first load.
- R2: On a clock edge with `load` high, `count` takes `load_value` on the next cycle; `mode_sel` and `bcd_sel` are captured only at a load; load has priority over a tick or gate edge in the same cycle; counting starts with the first enabled tick after the load edge.
- R3: An initial value of 0 acts as 65536 ticks in binary and 10000 ticks in decimal.
- R4: In modes 0, 1, 4 and 5 the count does not stop at zero: it decrements on through 0xFFFF (binary) or 0x9999 (decimal) and continues.
- R5: Mode 0: `out` is low from the cycle after a load until the elapsed ticks equal N, then stays high until the next load.
- R6: Mode 1: `out` is high while armed, goes low on the triggering gate rising edge, and goes high again when N ticks have elapsed.
- R7: Mode 2: the count reloads every N ticks, and `out` is high for exactly the one tick interval that begins at each period end, never right after the load.
- R8: Mode 3: the count reloads every N ticks, and `out` is high during the first ceil(N/2) ticks of each period and low for the rest.
- R9: Modes 4 and 5: `out` is high only in the tick interval where elapsed ticks equal N; mode 5 counts only after a gate rising edge.
- R10: In modes 0, 2, 3 and 4 a low gate freezes counting; in modes 1 and 5 the gate level does not stop counting.
- R11: A gate rising edge (gate high now, low on the previous clock) restarts counting from the initial value in modes 1, 2, 3 and 5, and has no effect in modes 0 and 4.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R13: With the decimal flag set, the count is four BCD digits (bits 15:12 thousands down to 3:0 units) and decrements in decimal, with 0000 followed by 9999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe, one count per high cycle |
| gate | input | 1 | Gate level; enables or triggers depending on mode |
| load | input | 1 | Load strobe for initial value, mode and decimal flag |
| load_value | input | 16 | Initial count (binary, or 4 BCD digits) |
| mode_sel | input | 3 | Operating mode code 0..7 |
| bcd_sel | input | 1 | 1 selects decimal counting |
| count | output | 16 | Live count value |
| out | output | 1 | Mode-dependent output waveform |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- a load captures the value;
- the count is frozen when no tick arrives;
- mode 0 holds `out` high once it has risen;
- the strobe and rate pulses in modes 2 and 4 last one tick;
- a mode 1 trigger drops `out`;
- in mode 3 `out` rises only at the start of a period.

Other behaviour can only be shown by the bench's scenarios, because it depends on how many ticks have elapsed:
- the exact cycle where `out` changes;
- the wrap values;
- the 65536 and 10000 full periods for an initial value of 0;
- decimal decrementing;
- ignored retriggers in modes 0 and 4.

The bench compares `count` and `out` on every cycle against a model built on elapsed ticks, under directed cases and seeded random traffic.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_STROBE,
        ST_TAIL
    } ictr_state_e;

    localparam logic [2:0] MD_TERM    = 3'd0;
    localparam logic [2:0] MD_ONESHOT = 3'd1;
    localparam logic [2:0] MD_RATE    = 3'd2;
    localparam logic [2:0] MD_SQUARE  = 3'd3;
    localparam logic [2:0] MD_SWSTB   = 3'd4;
    localparam logic [2:0] MD_HWSTB   = 3'd5;

    // codes 6 and 7 fold onto 2 and 3
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/ictr_span.sv
module ictr_span #(
    parameter int CNT_W  = 16,
    parameter bit BCD_EN = 1'b1,
    localparam int EL_W   = CNT_W + 1,
    localparam int DIGITS = CNT_W / 4
) (
    input  logic [CNT_W-1:0] init,
    input  logic             bcd,
    output logic [EL_W-1:0]  period
);
    localparam logic [EL_W-1:0] BIN_FULL = EL_W'(1) << CNT_W;
    localparam logic [EL_W-1:0] DEC_FULL = EL_W'(10 ** DIGITS);

    logic [EL_W-1:0] bin_len;
    assign bin_len = (init == '0) ? BIN_FULL : EL_W'(init);

    generate
        if (BCD_EN) begin : g_dec
            logic [EL_W-1:0] acc;
            always_comb begin
                acc = '0;
                for (int i = DIGITS - 1; i >= 0; i--) begin
                    acc = acc * EL_W'(10) + EL_W'(init[4*i +: 4]);
                end
            end
            assign period = bcd ? ((acc == '0) ? DEC_FULL : acc) : bin_len;
        end else begin : g_bin
            logic unused_bcd;
            assign unused_bcd = bcd;
            assign period     = bin_len;
        end
    endgenerate

endmodule

// File: rtl/ictr_step.sv
module ictr_step #(
    parameter int CNT_W  = 16,
    parameter bit BCD_EN = 1'b1,
    localparam int DIGITS = CNT_W / 4
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             bcd,
    output logic [CNT_W-1:0] nxt
);
    logic [CNT_W-1:0] bin_dec;
    assign bin_dec = cur - CNT_W'(1);

    generate
        if (BCD_EN) begin : g_dec
            logic [CNT_W-1:0] dec_dec;
            always_comb begin
                logic       borrow;
                logic [3:0] dig;
                borrow  = 1'b1;
                dec_dec = '0;
                for (int i = 0; i < DIGITS; i++) begin
                    dig = cur[4*i +: 4];
                    if (borrow && dig == 4'd0) begin
                        dec_dec[4*i +: 4] = 4'd9;
                    end else if (borrow) begin
                        dec_dec[4*i +: 4] = dig - 4'd1;
                        borrow = 1'b0;
                    end else begin
                        dec_dec[4*i +: 4] = dig;
                    end
                end
            end
            assign nxt = bcd ? dec_dec : bin_dec;
        end else begin : g_bin
            logic unused_bcd;
            assign unused_bcd = bcd;
            assign nxt        = bin_dec;
        end
    endgenerate

endmodule

// File: rtl/ictr_fsm.sv
module ictr_fsm
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int EL_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic [2:0]       mode_in,
    input  logic             bcd_in,
    input  logic [CNT_W-1:0] cnt_dec,
    input  logic [EL_W-1:0]  period,
    output logic [CNT_W-1:0] init_q,
    output logic             bcd_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             out
);
    ictr_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_d, init_d;
    logic [EL_W-1:0]  el_q, el_d, el_inc, half;
    logic [2:0]       mode_q, mode_d;
    logic             bcd_d, gate_q;
    logic             retrig, cnt_en, hit, gate_free, counting;

    assign gate_free = (mode_q == MD_ONESHOT) || (mode_q == MD_HWSTB);
    assign counting  = (state_q == ST_RUN) || (state_q == ST_STROBE) || (state_q == ST_TAIL);
    assign retrig    = gate && !gate_q && (state_q != ST_IDLE) &&
                       (mode_q inside {MD_ONESHOT, MD_RATE, MD_SQUARE, MD_HWSTB});
    assign cnt_en    = tick && counting && (gate || gate_free);
    assign el_inc    = el_q + EL_W'(1);
    assign hit       = (el_inc == period);
    assign half      = (period + EL_W'(1)) >> 1;

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        el_d    = el_q;
        init_d  = init_q;
        mode_d  = mode_q;
        bcd_d   = bcd_q;
        if (load) begin
            init_d  = load_value;
            mode_d  = mode_in;
            bcd_d   = bcd_in;
            cnt_d   = load_value;
            el_d    = '0;
            state_d = (mode_in == MD_ONESHOT || mode_in == MD_HWSTB) ? ST_ARMED : ST_RUN;
        end else if (retrig) begin
            cnt_d   = init_q;
            el_d    = '0;
            state_d = ST_RUN;
        end else if (cnt_en) begin
            cnt_d = cnt_dec;
            unique case (state_q)
                ST_RUN: begin
                    el_d = el_inc;
                    if (hit) begin
                        case (mode_q)
                            MD_RATE: begin
                                el_d    = '0;
                                cnt_d   = init_q;
                                state_d = ST_STROBE;
                            end
                            MD_SQUARE: begin
                                el_d  = '0;
                                cnt_d = init_q;
                            end
                            MD_SWSTB, MD_HWSTB: state_d = ST_STROBE;
                            default:            state_d = ST_TAIL;
                        endcase
                    end
                end
                ST_STROBE: begin
                    if (mode_q == MD_RATE) begin
                        if (hit) begin
                            el_d  = '0;
                            cnt_d = init_q;
                        end else begin
                            el_d    = el_inc;
                            state_d = ST_RUN;
                        end
                    end else begin
                        state_d = ST_TAIL;
                    end
                end
                ST_TAIL:  ;
                default:  ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            el_q    <= '0;
            init_q  <= '0;
            mode_q  <= MD_TERM;
            bcd_q   <= 1'b0;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            el_q    <= el_d;
            init_q  <= init_d;
            mode_q  <= mode_d;
            bcd_q   <= bcd_d;
            gate_q  <= gate;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   out = 1'b0;
            ST_ARMED:  out = (mode_q == MD_ONESHOT);
            ST_RUN:    out = (mode_q == MD_SQUARE) && (el_q < half);
            ST_STROBE: out = 1'b1;
            ST_TAIL:   out = (mode_q == MD_TERM) || (mode_q == MD_ONESHOT);
            default:   out = 1'b0;
        endcase
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_value)));

    // R10
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !retrig) |=> $stable(cnt_q));

    // R5
    term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TERM && out && !load) |=> out);

    // R6
    oneshot_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_ONESHOT && state_q == ST_ARMED && retrig && !load) |=> !out);

    // R7
    rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_RATE && out && cnt_en && !load && period != EL_W'(1)) |=> !out);

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SWSTB && state_q == ST_STROBE && cnt_en && !load) |=> !out);

    // R8
    square_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out) && mode_q == MD_SQUARE) |-> (el_q == '0));

endmodule

// File: rtl/interval_counter.sv
module interval_counter
    import ictr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit BCD_EN = 1'b1,
    localparam int EL_W  = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic [2:0]       mode_sel,
    input  logic             bcd_sel,
    output logic [CNT_W-1:0] count,
    output logic             out
);
    logic [CNT_W-1:0] init_q, cnt_q, cnt_dec;
    logic             bcd_q;
    logic [EL_W-1:0]  period;
    logic [2:0]       mode_f;

    // R12: alias folding before capture
    assign mode_f = fold_mode(mode_sel);

    ictr_span #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_span (
        .init   (init_q),
        .bcd    (bcd_q),
        .period (period)
    );

    ictr_step #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_step (
        .cur (cnt_q),
        .bcd (bcd_q),
        .nxt (cnt_dec)
    );

    ictr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .gate       (gate),
        .load       (load),
        .load_value (load_value),
        .mode_in    (mode_f),
        .bcd_in     (bcd_sel),
        .cnt_dec    (cnt_dec),
        .period     (period),
        .init_q     (init_q),
        .bcd_q      (bcd_q),
        .cnt_q      (cnt_q),
        .out        (out)
    );

    assign count = cnt_q;

endmodule

// File: tb/test_interval_counter.sv
module test_interval_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_value = '0;
    logic [2:0]  mode_sel = '0;
    logic        bcd_sel = 1'b0;
    logic [15:0] count;
    logic        out;

    always #5 clk = ~clk;

    interval_counter i_interval_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
        .load_value(load_value), .mode_sel(mode_sel), .bcd_sel(bcd_sel),
        .count(count), .out(out)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    string  cur_tag = "R1";
    bit     use_mode_tag = 1'b0;

    // reference model, elapsed-tick based
    bit     m_loaded = 0, m_run = 0, m_bcd = 0, prev_gate = 0;
    int     m_mode = 0, m_init = 0;
    longint m_d = 0;

    function automatic int bcd2bin(int c);
        return ((c >> 12) & 15) * 1000 + ((c >> 8) & 15) * 100 + ((c >> 4) & 15) * 10 + (c & 15);
    endfunction

    function automatic int bin2bcd(int v);
        return ((v / 1000) % 10) << 12 | ((v / 100) % 10) << 8 | ((v / 10) % 10) << 4 | (v % 10);
    endfunction

    function automatic int fold(int m);
        return (m >= 6) ? m - 4 : m;
    endfunction

    function automatic longint nlen();
        int b;
        if (m_bcd) begin
            b = bcd2bin(m_init);
            return (b == 0) ? 10000 : b;
        end
        return (m_init == 0) ? 65536 : m_init;
    endfunction

    function automatic int code(longint v);
        return m_bcd ? bin2bcd(int'(v % 10000)) : int'(v % 65536);
    endfunction

    function automatic int exp_out();
        longint n = nlen();
        if (!m_loaded) return 0;
        if (!m_run) return (m_mode == 1) ? 1 : 0;
        case (m_mode)
            0, 1:    return int'(m_d >= n);
            2:       return int'(m_d != 0 && (m_d % n) == 0);
            3:       return int'((m_d % n) < (n + 1) / 2);
            default: return int'(m_d == n);
        endcase
    endfunction

    function automatic int exp_count();
        longint n = nlen();
        longint full = m_bcd ? 10000 : 65536;
        longint r;
        if (!m_loaded) return 0;
        if (!m_run) return m_init;
        if (m_mode == 2 || m_mode == 3) begin
            r = m_d % n;
            return (r == 0) ? m_init : code(n - r);
        end
        return code(((n % full) - (m_d % full) + full) % full);
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model_edge(bit ld, int val, int md, bit bc, bit g, bit tk);
        bit rise = g && !prev_gate;
        if (ld) begin
            m_loaded = 1; m_mode = fold(md); m_init = val; m_bcd = bc; m_d = 0;
            m_run = !(m_mode == 1 || m_mode == 5);
        end else if (m_loaded && rise && (m_mode inside {1, 2, 3, 5})) begin
            m_run = 1; m_d = 0;
        end else if (m_run && tk && (g || m_mode == 1 || m_mode == 5)) begin
            m_d++;
        end
        prev_gate = g;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (mode %0d d=%0d)", tag, what, act, exp, m_mode, m_d);
        end
    endtask

    task automatic compare();
        string t = use_mode_tag ? mode_tag(m_mode) : cur_tag;
        chk(t, "out", int'(out), exp_out());
        chk(t, "count", int'(count), exp_count());
    endtask

    task automatic cyc(bit tk, bit g);
        tick = tk; gate = g; load = 0;
        model_edge(0, 0, 0, 0, g, tk);
        @(negedge clk);
        compare();
    endtask

    task automatic ld(int v, int md, bit bc, bit g, bit tk);
        load = 1; load_value = 16'(v); mode_sel = 3'(md); bcd_sel = bc; gate = g; tick = tk;
        model_edge(1, v, md, bc, g, tk);
        @(negedge clk);
        load = 0;
        compare();
    endtask

    task automatic run(int n, bit tk, bit g);
        for (int i = 0; i < n; i++) cyc(tk, g);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7741);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and no activity before a load
        cur_tag = "R1";
        compare();
        mode_sel = 3'd3;
        run(2, 1, 1); run(2, 1, 0); run(2, 1, 1);

        // R5: terminal count, reload drops out
        cur_tag = "R5";
        ld(5, 0, 0, 1, 1); run(8, 1, 1);
        ld(3, 0, 0, 1, 0); run(2, 1, 1);
        // R10: gate low freezes mode 0
        cur_tag = "R10";
        run(3, 1, 0); run(3, 1, 1);

        // R6: one-shot armed, triggered, retriggered
        cur_tag = "R6";
        ld(4, 1, 0, 0, 1); run(3, 1, 0); run(3, 1, 1);
        cur_tag = "R11";
        cyc(1, 0); run(7, 1, 1);

        // R7: rate generator with pause and restart
        cur_tag = "R7";
        ld(3, 2, 0, 1, 1); run(8, 1, 1);
        cur_tag = "R10";
        run(2, 1, 0);
        cur_tag = "R11";
        cyc(0, 1); run(5, 1, 1);
        cur_tag = "R7";
        ld(1, 2, 0, 1, 1); run(3, 1, 1);

        // R8: square wave, odd, even and unit periods
        cur_tag = "R8";
        ld(5, 3, 0, 1, 1); run(12, 1, 1);
        ld(4, 3, 0, 1, 1); run(10, 1, 1);
        ld(1, 3, 0, 1, 1); run(3, 1, 1);

        // R9: software and hardware strobe
        cur_tag = "R9";
        ld(3, 4, 0, 1, 1); run(2, 1, 1);
        cur_tag = "R11";
        run(2, 1, 0); run(6, 1, 1);
        cur_tag = "R9";
        ld(2, 5, 0, 0, 1); run(2, 1, 0); run(6, 1, 1);

        // R12: alias codes
        cur_tag = "R12";
        ld(3, 6, 0, 1, 1); run(7, 1, 1);
        ld(4, 7, 0, 1, 1); run(9, 1, 1);

        // R4: wraparound in one-shot modes
        cur_tag = "R4";
        ld(2, 0, 0, 1, 1); run(5, 1, 1);
        ld(1, 4, 0, 1, 1); run(4, 1, 1);

        // R13: decimal counting
        cur_tag = "R13";
        ld(16'h0012, 0, 1, 1, 1); run(16, 1, 1);
        ld(16'h0010, 3, 1, 1, 1); run(12, 1, 1);
        ld(16'h0001, 1, 1, 0, 1); run(2, 1, 0); run(4, 1, 1);

        // R2: capture only at load, load priority, sparse ticks
        cur_tag = "R2";
        ld(6, 0, 0, 1, 1);
        mode_sel = 3'd3; bcd_sel = 1'b1;
        cyc(0, 1); cyc(1, 1); cyc(0, 1); cyc(1, 1); cyc(0, 1);
        ld(9, 2, 0, 1, 1); cyc(1, 1);

        // R3: zero initial value, binary and decimal
        cur_tag = "R3";
        ld(0, 0, 0, 1, 1); run(65538, 1, 1);
        ld(0, 2, 1, 1, 1); run(10002, 1, 1);

        // random traffic
        use_mode_tag = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            bit g = gate;
            bit tk = ($urandom % 100) < 75;
            if (($urandom % 100) < 10) g = !g;
            if (($urandom % 100) < 4) begin
                int v = $urandom % 10;
                int md = $urandom % 8;
                bit bc = $urandom % 2;
                ld(bc ? bin2bcd(v) : v, md, bc, g, tk);
            end else begin
                cyc(tk, g);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule